// File: doc/BRIEF.md
# Line-Bounded Instruction Fetch Address Generator

This block turns a fetch decision for one wavefront slot into a memory read request. It receives the slot's program counter, which counts 32-bit words, and the slot's base byte address. It also receives a description of the instructions already sitting in that slot's instruction buffer. The PC is moved forward past those buffered instructions, so that the next fetch starts right after them. The word offset is turned into a byte address on top of the base. The request length is then clipped so that it never runs past the end of the cache line that holds the start address.

Requests leave through a valid/ready port. A request that the port does not take is not lost. It goes into an in-order retry queue and the port is flagged as stalled. While the flag is set, newly built requests join the tail of the queue instead of going out. A retry pulse starts a drain that re-sends the queued requests oldest first, and the stall flag drops once the queue is empty. Each request carries its slot index, so the returning data can be matched to its wavefront. Address translation and the memory behind the port are outside this block.

Top module: `linefetch_addr_gen`

## Requirements
- R1: After reset, and until the first request is accepted, `out_valid` and `port_stalled` are 0.
- R2: The request address is `in_base + 4 * (in_pc + W)`. W sums one word for each narrow entry (flag 0, 4 bytes) and two words for each wide entry (flag 1, 8 bytes). Only entries 0 to `in_buf_count-1` of `in_buf_wide` count; bit i is entry i, and flags at higher positions have no effect on the address.
- R3: The request size runs from the address to the next line boundary (LINE_BYTES, 64 by default). When the address is already a multiple of LINE_BYTES, the size is one full line. The request never crosses a line boundary.
- R4: A request taken on a clock edge with `in_valid` high while the port is open appears on `out_valid` for the following cycle, together with its slot index, address and size.
- R5: When the port is open and `out_valid` is high with `out_ready` low at a clock edge, the request goes into the retry queue and `port_stalled` is 1 from the next cycle.
- R6: While the port is stalled and no drain is running, `out_valid` stays 0, and new requests are appended to the retry queue.
- R7: A `retry_pulse` while stalled starts a drain. The queued requests are presented oldest first and leave in issue order. If the head is refused during the drain, the drain stops and waits for a new pulse; the head request stays queued. A pulse while the port is open has no effect.
- R8: `port_stalled` returns to 0 in the cycle after the last queued request is accepted, provided that no new request joined the queue on that edge. It is never 0 while the queue holds requests.
- R9: The retry queue holds SLOTS entries, one per wavefront slot, and is never pushed while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetch is to be built for `in_slot` this cycle |
| in_slot | input | SLOT_W | Wavefront slot index |
| in_pc | input | ADDR_W | Program counter in 32-bit words |
| in_base | input | ADDR_W | Base byte address of the slot's code |
| in_buf_count | input | CNT_W | Number of valid instruction buffer entries |
| in_buf_wide | input | BUF_DEPTH | Per-entry flag, 1 = 8-byte instruction |
| out_valid | output | 1 | Request present |
| out_ready | input | 1 | Downstream accepts the request |
| out_addr | output | ADDR_W | Request byte address |
| out_size | output | SIZE_W | Request length in bytes |
| out_slot | output | SLOT_W | Slot index carried with the request |
| retry_pulse | input | 1 | Downstream signals that a refused port may retry |
| port_stalled | output | 1 | Port is stalled, requests are being queued |

## Verification
The checker watches, on every cycle, that a request never crosses a line and is a full line when aligned. It also checks that a refusal on an open port raises the stall flag, that a stalled port outside a drain stays silent, and that the flag is never clear while the queue holds entries. It further checks that a retry pulse starts a drain, and that the queue is never pushed when full. Only the bench scenarios can show that the address arithmetic skips exactly the buffered words, that a queue full of refused requests leaves in issue order with the right contents, and that a refusal in the middle of a drain keeps the head request for the next pulse.

// File: rtl/linefetch_pkg.sv
package linefetch_pkg;

   typedef enum logic [1:0] {
      PORT_OPEN    = 2'd0,
      PORT_STALLED = 2'd1,
      PORT_DRAIN   = 2'd2
   } port_state_e;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/linefetch_word_offset.sv
// Advances the program counter (in words) past the buffered instructions.
module linefetch_word_offset #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned BUF_DEPTH = 4,
   parameter int unsigned CNT_W     = 3
) (
   input  logic [PC_W-1:0]      pc,
   input  logic [CNT_W-1:0]     count,
   input  logic [BUF_DEPTH-1:0] wide,
   output logic [PC_W-1:0]      adj_pc
);
   logic [1:0] step [BUF_DEPTH];

   for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_step
      // an entry only counts when it lies below the fill count
      assign step[g] = (CNT_W'(g) < count) ? (wide[g] ? 2'd2 : 2'd1) : 2'd0;
   end

   always_comb begin
      adj_pc = pc;
      for (int i = 0; i < BUF_DEPTH; i++) begin
         adj_pc = adj_pc + PC_W'(step[i]);
      end
   end
endmodule

// File: rtl/linefetch_line_clip.sv
// Clips a request to the end of the line holding its start address.
module linefetch_line_clip #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned SIZE_W     = 7,
   parameter bit          SPLIT_FORM = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SIZE_W-1:0] size
);
   localparam int unsigned LB = $clog2(LINE_BYTES);

   if (SPLIT_FORM) begin : g_split
      // round-up split point, computed one bit wider to avoid wrap
      logic [ADDR_W:0] ext, split, diff;
      assign ext   = {1'b0, addr};
      assign split = (ext + (ADDR_W+1)'(LINE_BYTES - 1))
                     & ~((ADDR_W+1)'(LINE_BYTES - 1));
      assign diff  = split - ext;
      assign size  = (split > ext) ? diff[SIZE_W-1:0] : SIZE_W'(LINE_BYTES);
   end else begin : g_lowbits
      // same result from the in-line offset only
      logic [LB-1:0] offs;
      assign offs = addr[LB-1:0];
      assign size = (offs == '0) ? SIZE_W'(LINE_BYTES)
                                 : SIZE_W'(LINE_BYTES) - SIZE_W'(offs);
   end
endmodule

// File: rtl/linefetch_retry_fifo.sv
// In-order holding queue for refused requests.
module linefetch_retry_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full,
   output logic         last
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign last    = (cnt == CNT_W'(1));
   assign rdata   = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/linefetch_addr_gen.sv
module linefetch_addr_gen #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned SLOTS      = 8,
   parameter int unsigned BUF_DEPTH  = 4,
   parameter bit          SPLIT_FORM = 1'b1,
   localparam int unsigned SLOT_W    = $clog2(SLOTS),
   localparam int unsigned CNT_W     = $clog2(BUF_DEPTH + 1),
   localparam int unsigned SIZE_W    = $clog2(LINE_BYTES) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [SLOT_W-1:0]    in_slot,
   input  logic [ADDR_W-1:0]    in_pc,
   input  logic [ADDR_W-1:0]    in_base,
   input  logic [CNT_W-1:0]     in_buf_count,
   input  logic [BUF_DEPTH-1:0] in_buf_wide,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [ADDR_W-1:0]    out_addr,
   output logic [SIZE_W-1:0]    out_size,
   output logic [SLOT_W-1:0]    out_slot,
   input  logic                 retry_pulse,
   output logic                 port_stalled
);
   import linefetch_pkg::*;

   localparam int unsigned REQ_W = SLOT_W + ADDR_W + SIZE_W;

   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 8) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 8");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (BUF_DEPTH < 1 || ADDR_W <= SIZE_W + WORD_SHIFT) begin : g_bad_shape
      $error("BUF_DEPTH or ADDR_W out of range");
   end

   // ---------------- address and size ----------------
   logic [ADDR_W-1:0] adj_pc, byte_addr;
   logic [SIZE_W-1:0] clip_size;

   linefetch_word_offset #(
      .PC_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)
   ) u_offset (
      .pc(in_pc), .count(in_buf_count), .wide(in_buf_wide), .adj_pc(adj_pc)
   );

   assign byte_addr = in_base + {adj_pc[ADDR_W-WORD_SHIFT-1:0], {WORD_SHIFT{1'b0}}};

   linefetch_line_clip #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SIZE_W(SIZE_W),
      .SPLIT_FORM(SPLIT_FORM)
   ) u_clip (
      .addr(byte_addr), .size(clip_size)
   );

   // ---------------- request register ----------------
   logic             pipe_v;
   logic [REQ_W-1:0] pipe_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe_v   <= 1'b0;
         pipe_req <= '0;
      end else begin
         pipe_v <= in_valid;
         if (in_valid) pipe_req <= {in_slot, byte_addr, clip_size};
      end
   end

   // ---------------- port control ----------------
   port_state_e      state, state_nx;
   logic             draining;
   logic             q_push, q_pop, q_empty, q_full, q_last;
   logic [REQ_W-1:0] q_head, out_req;

   assign draining     = (state == PORT_DRAIN);
   assign port_stalled = (state != PORT_OPEN);

   assign out_valid = draining ? !q_empty : (pipe_v && state == PORT_OPEN);
   assign out_req   = draining ? q_head : pipe_req;
   assign {out_slot, out_addr, out_size} = out_req;

   // refused on an open port, or arriving while the port is held
   assign q_push = pipe_v && ((state != PORT_OPEN) || !out_ready);
   assign q_pop  = draining && out_valid && out_ready;

   linefetch_retry_fifo #(
      .W(REQ_W), .DEPTH(SLOTS)
   ) u_retry (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .wdata(pipe_req), .pop(q_pop),
      .rdata(q_head), .empty(q_empty), .full(q_full), .last(q_last)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         PORT_OPEN:    if (pipe_v && !out_ready) state_nx = PORT_STALLED;
         PORT_STALLED: if (retry_pulse)          state_nx = PORT_DRAIN;
         PORT_DRAIN: begin
            if (!out_ready)                 state_nx = PORT_STALLED;
            else if (q_last && !q_push)     state_nx = PORT_OPEN;
         end
         default:                          state_nx = PORT_OPEN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= PORT_OPEN;
      else        state <= state_nx;
   end
endmodule

// File: rtl/linefetch_addr_gen_chk.sv
module linefetch_addr_gen_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64,
   localparam int unsigned LB        = $clog2(LINE_BYTES),
   localparam int unsigned SIZE_W    = LB + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              retry_pulse,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic [SIZE_W-1:0] out_size,
   input logic              port_stalled,
   input logic              draining,
   input logic              q_push,
   input logic              q_full,
   input logic              q_empty
);
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!out_valid && !port_stalled));

   assert_within_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_size != '0) &&
                    (({1'b0, out_addr[LB-1:0]} + out_size) <= SIZE_W'(LINE_BYTES)));

   assert_aligned_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_addr[LB-1:0] == '0) |-> out_size == SIZE_W'(LINE_BYTES));

   assert_issue_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !port_stalled && !(out_valid && !out_ready)) |=> out_valid);

   assert_refuse_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !port_stalled) |=> port_stalled);

   assert_stalled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (port_stalled && !draining) |-> !out_valid);

   assert_retry_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_pulse && port_stalled && !draining) |=> draining);

   assert_open_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !port_stalled |-> q_empty);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> !q_full);
endmodule

bind linefetch_addr_gen linefetch_addr_gen_chk #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .retry_pulse(retry_pulse),
   .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
   .out_size(out_size), .port_stalled(port_stalled), .draining(draining),
   .q_push(q_push), .q_full(q_full), .q_empty(q_empty)
);

// File: tb/tb_linefetch_addr_gen.sv
module tb_linefetch_addr_gen;
   localparam int unsigned ADDR_W = 32, LINE = 64, SLOTS = 8, BUF = 4;
   localparam int unsigned SLOT_W = 3, CNT_W = 3, SIZE_W = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 0, out_ready = 1, retry_pulse = 0;
   logic [SLOT_W-1:0] in_slot = '0;
   logic [ADDR_W-1:0] in_pc = '0, in_base = '0;
   logic [CNT_W-1:0]  in_buf_count = '0;
   logic [BUF-1:0]    in_buf_wide = '0;
   logic out_valid, port_stalled;
   logic [ADDR_W-1:0] out_addr;
   logic [SIZE_W-1:0] out_size;
   logic [SLOT_W-1:0] out_slot;

   always #10 clk = ~clk;  // 50 MHz

   linefetch_addr_gen #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .SLOTS(SLOTS),
                        .BUF_DEPTH(BUF)) dut (.*);

   typedef struct packed {
      logic [SLOT_W-1:0] slot;
      logic [ADDR_W-1:0] addr;
      logic [SIZE_W-1:0] size;
   } exp_t;

   exp_t exp_q[$];
   int   nchk = 0, nfail = 0;
   bit   done = 0;

   task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // driver: builds one request and records what must come out (R2, R3)
   task automatic issue(int slot, int base, int pc, int cnt, logic [BUF-1:0] wide);
      exp_t e;
      logic [ADDR_W-1:0] words, a;
      words = ADDR_W'(pc);
      for (int i = 0; i < cnt; i++) words += wide[i] ? 2 : 1;
      a = ADDR_W'(base) + words * 4;
      e.slot = SLOT_W'(slot);
      e.addr = a;
      e.size = (a % LINE == 0) ? SIZE_W'(LINE) : SIZE_W'(LINE - (a % LINE));
      exp_q.push_back(e);
      @(posedge clk); #2;
      in_valid = 1; in_slot = SLOT_W'(slot); in_base = ADDR_W'(base);
      in_pc = ADDR_W'(pc); in_buf_count = CNT_W'(cnt); in_buf_wide = wide;
      @(posedge clk); #2;
      in_valid = 0;
   endtask

   task automatic cycle(); @(posedge clk); #2; endtask

   task automatic pulse_retry();
      @(posedge clk); #2 retry_pulse = 1;
      @(posedge clk); #2 retry_pulse = 0;
   endtask

   task automatic wait_open(string req);
      int n = 0;
      while ((port_stalled || exp_q.size() != 0) && n < 40) begin cycle(); n++; end
      chk(req, 64'(n < 40), 64'd1);
   endtask

   // monitor: compares every accepted request with the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         exp_t e;
         nchk++;
         if (exp_q.size() == 0) begin
            nfail++;
            $display("FAIL R4,R7 unexpected request actual=%0h expected=none",
                     {out_slot, out_addr, out_size});
         end else begin
            e = exp_q.pop_front();
            if (out_slot !== e.slot || out_addr !== e.addr || out_size !== e.size) begin
               nfail++;
               $display("FAIL R2,R3,R7 request actual=%0h/%0h/%0d expected=%0h/%0h/%0d",
                        out_slot, out_addr, out_size, e.slot, e.addr, e.size);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog R8 actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) cycle();
      rst_n = 1;
      cycle();
      chk("R1 out_valid after reset", 64'(out_valid), 0);
      chk("R1 port_stalled after reset", 64'(port_stalled), 0);

      // open port, ready high: main address and size patterns
      issue(0, 'h1000, 0, 0, 4'b0000);           // aligned, full line R3
      chk("R4 valid one cycle after issue", 64'(out_valid), 1);
      issue(1, 'h2000, 3, 2, 4'b0011);           // two wide entries R2
      issue(2, 'h3004, 5, 1, 4'b1110);           // flags above count ignored R2
      issue(3, 'h4000, 11, 4, 4'b0101);          // mixed widths R2
      issue(4, 'h5000, 15, 0, 4'b1111);          // last word of line R3
      issue(5, 'h6000, 14, 1, 4'b0001);          // wide entry ends on boundary R3
      cycle();
      chk("R4 all open-port requests consumed", 64'(exp_q.size()), 0);

      // retry pulse on an open port is ignored (R7)
      pulse_retry();
      chk("R7 retry while open keeps port open", 64'(port_stalled), 0);
      chk("R7 retry while open sends nothing", 64'(out_valid), 0);

      // refusal, stall, queueing, drain
      out_ready = 0;
      issue(6, 'h7010, 2, 3, 4'b0010);
      chk("R4 refused request still presented", 64'(out_valid), 1);
      cycle();
      chk("R5 refusal sets stall", 64'(port_stalled), 1);
      chk("R6 stalled port silent", 64'(out_valid), 0);
      issue(7, 'h8000, 1, 0, 4'b0000);
      chk("R6 stalled port silent after new request", 64'(out_valid), 0);
      issue(0, 'h9020, 7, 2, 4'b0001);
      cycle();
      chk("R6 still silent before retry", 64'(out_valid), 0);
      chk("R8 stall held while queue full of work", 64'(port_stalled), 1);
      out_ready = 1;
      pulse_retry();
      wait_open("R7 drain completes");
      chk("R8 stall cleared after drain", 64'(port_stalled), 0);

      // refusal in the middle of a drain
      out_ready = 0;
      issue(1, 'hA03C, 0, 0, 4'b0000);
      cycle();
      issue(2, 'hB000, 8, 4, 4'b1111);
      pulse_retry();
      chk("R7 drain presents head", 64'(out_valid), 1);
      cycle();
      chk("R7 refused head stops drain", 64'(out_valid), 0);
      chk("R7 port stays stalled", 64'(port_stalled), 1);
      chk("R7 head kept queued", 64'(exp_q.size()), 2);
      out_ready = 1;
      cycle();
      chk("R6 no send without new pulse", 64'(exp_q.size()), 2);
      pulse_retry();
      wait_open("R7 second drain completes");
      chk("R8 open after second drain", 64'(port_stalled), 0);

      // full queue: one refused request per slot (R9)
      out_ready = 0;
      for (int s = 0; s < SLOTS; s++) issue(s, 'hC000 + s * 64, s, s % 5, 4'b1010);
      cycle();
      chk("R9 stalled with every slot queued", 64'(port_stalled), 1);
      out_ready = 1;
      pulse_retry();
      wait_open("R9 full queue drains");
      chk("R8 open after full drain", 64'(port_stalled), 0);

      repeat (3) cycle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule